// File: doc/BRIEF.md
# Write-Through Invalidating Snoopy Cache

This block is a small direct-mapped cache for one processor that shares a broadcast bus with peer caches. Coherence is kept per cache line. A load that misses fetches the whole line from memory, one word at a time, and keeps it valid. A load that hits answers from the local copy without touching memory.

Every store goes straight to memory. A store that hits also updates the local copy. A store that misses does not allocate a line. Once the memory write has been acknowledged, the controller waits for the bus grant and then puts out a one-cycle invalidation that carries the line address. Peer caches watching the bus drop their copy, so their next load of that line misses and reads the new value from memory.

In the other direction, the block watches invalidations from its peers. It clears its own line when both index and tag match, and it ignores the message otherwise. A snoop that arrives in the same cycle as a local request takes effect first. A snoop that hits the line currently being filled lets the load complete, but the line is not kept valid.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset the block is ready for a request (`cpuReady`=1), holds no memory request and no invalidation, and every line is invalid, so the first load of any address misses.
- R2: A load miss reads the whole line from memory in ascending word order, starting at the line-aligned address (word address with the low log2(WORDS) bits cleared). It returns the requested word with a one-cycle `cpuRespValid` pulse while `cpuReady` is high, and leaves the line valid.
- R3: A load hit makes no memory access and pulses `cpuRespValid` with the cached word in the cycle right after acceptance.
- R4: Every store writes its word to memory (`memReq` and `memWe` high from the cycle after acceptance), whether it hits or misses.
- R5: A store hit also updates the cached word, so a later load hits and returns the new value. A store miss does not allocate: the line that was there stays, and a later load of the stored line misses.
- R6: After a store's memory write is acknowledged, the block raises `invOutValid` for exactly one cycle, only while `busGrant` is high, with `invOutAddr` equal to the store's line address (word address without its low log2(WORDS) bits). It waits as long as the grant is low, and it answers the store only after the invalidation.
- R7: A snooped invalidation (`snpValid` with line address `snpAddr`) that matches a valid line's index and tag invalidates it. The next load of that line misses and returns the current memory value.
- R8: A snooped invalidation whose tag differs from the indexed line, or whose line is not cached, changes nothing: the next load of the cached line still hits.
- R9: A snoop in the same cycle as an accepted local load of the same line is applied first, so the load misses and is fetched from memory.
- R10: A snoop that matches the line being filled lets the current load complete with the fetched data, but the line is left invalid, so the next load of it misses.
- R11: A snooped invalidation never causes `invOutValid`.
- R12: While `memReq` is high and not yet acknowledged, `memAddr`, `memWe` and `memReq` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor request present |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Word address of the request |
| cpuWdata | input | DATA_W | Store data |
| cpuReady | output | 1 | Block can accept a request this cycle |
| cpuRespValid | output | 1 | One-cycle completion pulse |
| cpuRdata | output | DATA_W | Load result, valid with cpuRespValid |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = memory write |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memAck | input | 1 | Memory completes the current access |
| memRdata | input | DATA_W | Memory read data, valid with memAck |
| busGrant | input | 1 | Permission to drive the invalidation bus |
| invOutValid | output | 1 | Outgoing invalidation strobe |
| invOutAddr | output | ADDR_W-log2(WORDS) | Line address of outgoing invalidation |
| snpValid | input | 1 | Incoming peer invalidation strobe |
| snpAddr | input | ADDR_W-log2(WORDS) | Line address of incoming invalidation |

## Verification
A stale valid bit or tag shows up at the ports in the very next load of that line. Either no memory reads occur where the bench expects four, or the bench sees a fill where it expects a one-cycle hit, and a peer's newer memory value is then returned wrong. A broken fill counter or kill flag shows up within one fill as out-of-order read addresses, or as a hit after a snooped fill. A fault in the store path shows up before the store completes: a missing memory write, an invalidation without grant or with the wrong line address, or a repeated invalidation pulse.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRMEM = 2'd2,
    ST_BCAST = 2'd3
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;     // request taken this cycle
    logic fillMode;   // memory address comes from fill counter
    logic beatAck;    // one fill word returned
    logic fillDone;   // last fill word returned
    logic storeDone;  // invalidation sent, store complete
  } dpStrobes_t;

endpackage

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl
  import wt_cache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReqValid,
  input  logic       cpuWe,
  input  logic       lookupHit,
  input  logic       lastBeat,
  input  logic       memAck,
  input  logic       busGrant,
  output dpStrobes_t stb,
  output logic       cpuReady,
  output logic       memReq,
  output logic       memWe,
  output logic       invOutValid
);

  ctlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    cpuReady      = (state == ST_IDLE);
    memReq        = (state == ST_FILL) || (state == ST_WRMEM);
    memWe         = (state == ST_WRMEM);
    invOutValid   = (state == ST_BCAST) && busGrant;

    stb.accept    = cpuReady && cpuReqValid;
    stb.fillMode  = (state == ST_FILL);
    stb.beatAck   = (state == ST_FILL) && memAck;
    stb.fillDone  = stb.beatAck && lastBeat;
    stb.storeDone = invOutValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (stb.accept) begin
          if (cpuWe)           stateNext = ST_WRMEM;
          else if (!lookupHit) stateNext = ST_FILL;
        end
      end
      ST_FILL:  if (stb.fillDone) stateNext = ST_IDLE;
      ST_WRMEM: if (memAck)       stateNext = ST_BCAST;
      ST_BCAST: if (busGrant)     stateNext = ST_IDLE;
      default:                    stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/wt_cache_dp.sv
module wt_cache_dp
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  dpStrobes_t                           stb,
  input  logic                                 cpuWe,
  input  logic [ADDR_W-1:0]                    cpuAddr,
  input  logic [DATA_W-1:0]                    cpuWdata,
  input  logic                                 snpValid,
  input  logic [ADDR_W-$clog2(WORDS)-1:0]      snpAddr,
  input  logic [DATA_W-1:0]                    memRdata,
  output logic                                 lookupHit,
  output logic                                 lastBeat,
  output logic                                 cpuRespValid,
  output logic [DATA_W-1:0]                    cpuRdata,
  output logic [ADDR_W-1:0]                    memAddr,
  output logic [DATA_W-1:0]                    memWdata,
  output logic [ADDR_W-$clog2(WORDS)-1:0]      invOutAddr
);

  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;
  localparam int CELLS  = LINES * WORDS;

  logic [LINES-1:0]  validArr;
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [CELLS];

  // incoming request fields
  logic [IDX_W-1:0]  inIdx;
  logic [TAG_W-1:0]  inTag;
  logic [OFF_W-1:0]  inOff;
  logic [LINE_W-1:0] inLine;

  // snoop fields
  logic [IDX_W-1:0]  snIdx;
  logic [TAG_W-1:0]  snTag;

  // latched request
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic [LINE_W-1:0] reqLine;
  logic [IDX_W-1:0]  reqIdx;
  logic [OFF_W-1:0]  reqOff;

  logic [OFF_W-1:0]  beat;
  logic              fillKilled;
  logic [DATA_W-1:0] fillWord;

  logic snoopHitsIn;
  logic snoopHitsReq;
  logic snoopKill;

  always_comb begin
    inLine  = cpuAddr[ADDR_W-1:OFF_W];
    inIdx   = cpuAddr[OFF_W +: IDX_W];
    inTag   = cpuAddr[ADDR_W-1 -: TAG_W];
    inOff   = cpuAddr[OFF_W-1:0];
    snIdx   = snpAddr[IDX_W-1:0];
    snTag   = snpAddr[LINE_W-1 -: TAG_W];
    reqLine = reqAddr[ADDR_W-1:OFF_W];
    reqIdx  = reqAddr[OFF_W +: IDX_W];
    reqOff  = reqAddr[OFF_W-1:0];

    snoopHitsIn  = snpValid && (snpAddr == inLine);
    snoopHitsReq = snpValid && (snpAddr == reqLine);
    snoopKill    = snpValid && validArr[snIdx] && (tagArr[snIdx] == snTag);

    // a snoop on the same line this cycle takes precedence
    lookupHit = validArr[inIdx] && (tagArr[inIdx] == inTag) && !snoopHitsIn;
    lastBeat  = (beat == OFF_W'(WORDS - 1));

    memAddr    = stb.fillMode ? {reqLine, beat} : reqAddr;
    memWdata   = reqWdata;
    invOutAddr = reqLine;
  end

  // request latch and fill counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr    <= '0;
      reqWdata   <= '0;
      beat       <= '0;
      fillKilled <= 1'b0;
      fillWord   <= '0;
    end else begin
      if (stb.accept) begin
        reqAddr    <= cpuAddr;
        reqWdata   <= cpuWdata;
        beat       <= '0;
        fillKilled <= 1'b0;
      end else begin
        if (stb.beatAck) begin
          beat <= beat + 1'b1;
          if (beat == reqOff) fillWord <= memRdata;
        end
        if (stb.fillMode && snoopHitsReq) fillKilled <= 1'b1;
      end
    end
  end

  // valid and tag state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr <= '0;
      for (int i = 0; i < LINES; i++) tagArr[i] <= '0;
    end else begin
      if (stb.accept && !cpuWe && !lookupHit) begin
        validArr[inIdx] <= 1'b0;
        tagArr[inIdx]   <= inTag;
      end
      if (stb.fillDone) validArr[reqIdx] <= !(fillKilled || snoopHitsReq);
      if (snoopKill)    validArr[snIdx]  <= 1'b0;
    end
  end

  // data storage
  always_ff @(posedge clk) begin
    if (stb.accept && cpuWe && lookupHit) dataArr[{inIdx, inOff}] <= cpuWdata;
    if (stb.beatAck)                      dataArr[{reqIdx, beat}] <= memRdata;
  end

  // response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRespValid <= 1'b0;
      cpuRdata     <= '0;
    end else begin
      cpuRespValid <= 1'b0;
      if (stb.accept && !cpuWe && lookupHit) begin
        cpuRespValid <= 1'b1;
        cpuRdata     <= dataArr[{inIdx, inOff}];
      end else if (stb.fillDone) begin
        cpuRespValid <= 1'b1;
        cpuRdata     <= (beat == reqOff) ? memRdata : fillWord;
      end else if (stb.storeDone) begin
        cpuRespValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cpuReqValid,
  input  logic                            cpuWe,
  input  logic [ADDR_W-1:0]               cpuAddr,
  input  logic [DATA_W-1:0]               cpuWdata,
  output logic                            cpuReady,
  output logic                            cpuRespValid,
  output logic [DATA_W-1:0]               cpuRdata,
  output logic                            memReq,
  output logic                            memWe,
  output logic [ADDR_W-1:0]               memAddr,
  output logic [DATA_W-1:0]               memWdata,
  input  logic                            memAck,
  input  logic [DATA_W-1:0]               memRdata,
  input  logic                            busGrant,
  output logic                            invOutValid,
  output logic [ADDR_W-$clog2(WORDS)-1:0] invOutAddr,
  input  logic                            snpValid,
  input  logic [ADDR_W-$clog2(WORDS)-1:0] snpAddr
);

  dpStrobes_t stb;
  logic       lookupHit;
  logic       lastBeat;

  wt_cache_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuReqValid (cpuReqValid),
    .cpuWe       (cpuWe),
    .lookupHit   (lookupHit),
    .lastBeat    (lastBeat),
    .memAck      (memAck),
    .busGrant    (busGrant),
    .stb         (stb),
    .cpuReady    (cpuReady),
    .memReq      (memReq),
    .memWe       (memWe),
    .invOutValid (invOutValid)
  );

  wt_cache_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINES  (LINES),
    .WORDS  (WORDS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cpuWe        (cpuWe),
    .cpuAddr      (cpuAddr),
    .cpuWdata     (cpuWdata),
    .snpValid     (snpValid),
    .snpAddr      (snpAddr),
    .memRdata     (memRdata),
    .lookupHit    (lookupHit),
    .lastBeat     (lastBeat),
    .cpuRespValid (cpuRespValid),
    .cpuRdata     (cpuRdata),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .invOutAddr   (invOutAddr)
  );

endmodule

// File: rtl/wt_snoop_cache_chk.sv
module wt_snoop_cache_chk #(
  parameter int ADDR_W = 10,
  parameter int LINE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReqValid,
  input logic              cpuWe,
  input logic              cpuReady,
  input logic              cpuRespValid,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic              busGrant,
  input logic              invOutValid,
  input logic [LINE_W-1:0] invOutAddr
);

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> cpuReady && !memReq && !invOutValid);

  p_store_through_r4: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady && cpuReqValid && cpuWe |=> memReq && memWe);

  p_load_starts_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady && cpuReqValid && !cpuWe |=> cpuRespValid || (memReq && !memWe));

  p_resp_when_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuRespValid |-> cpuReady);

  p_inv_needs_grant_r6: assert property (@(posedge clk) disable iff (!rstN)
    invOutValid |-> busGrant && !cpuReady && !memReq);

  p_inv_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    invOutValid |=> !invOutValid && cpuRespValid);

  p_inv_addr_steady_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck |=> invOutAddr == $past(memAddr[ADDR_W-1 -: LINE_W]));

  p_snoop_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !invOutValid);

  p_hold_request_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

endmodule

bind wt_snoop_cache wt_snoop_cache_chk #(
  .ADDR_W (ADDR_W),
  .LINE_W (ADDR_W - $clog2(WORDS))
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cpuReqValid  (cpuReqValid),
  .cpuWe        (cpuWe),
  .cpuReady     (cpuReady),
  .cpuRespValid (cpuRespValid),
  .memReq       (memReq),
  .memWe        (memWe),
  .memAddr      (memAddr),
  .memAck       (memAck),
  .busGrant     (busGrant),
  .invOutValid  (invOutValid),
  .invOutAddr   (invOutAddr)
);

// File: tb/wt_snoop_cache_tb.sv
`timescale 1ns/1ps
module wt_snoop_cache_tb;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int LINE_W = 8;
  localparam int LAT    = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cpuReqValid = 1'b0;
  logic              cpuWe = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic              cpuReady;
  logic              cpuRespValid;
  logic [DATA_W-1:0] cpuRdata;
  logic              memReq;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic              memAck = 1'b0;
  logic [DATA_W-1:0] memRdata = '0;
  logic              busGrant = 1'b1;
  logic              invOutValid;
  logic [LINE_W-1:0] invOutAddr;
  logic              snpValid = 1'b0;
  logic [LINE_W-1:0] snpAddr = '0;

  always #2 clk = ~clk;

  wt_snoop_cache u_dut (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRespValid(cpuRespValid), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .busGrant(busGrant),
    .invOutValid(invOutValid), .invOutAddr(invOutAddr),
    .snpValid(snpValid), .snpAddr(snpAddr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // memory reference model
  logic [DATA_W-1:0] mem [1 << ADDR_W];
  int rdBeats = 0;
  int wrCount = 0;
  int waitCnt = 0;
  int holdErr = 0;
  logic [ADDR_W-1:0] holdAddr;
  logic              holdWe;
  logic [ADDR_W-1:0] rdLog [$];

  initial for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 32'hA500_0000 | i;

  always @(negedge clk) begin
    if (rstN && memReq && !memAck) begin
      if (waitCnt == 0) begin
        holdAddr = memAddr;
        holdWe   = memWe;
      end else if (memAddr != holdAddr || memWe != holdWe) begin
        holdErr++;
      end
      if (waitCnt == LAT) begin
        memAck  = 1'b1;
        waitCnt = 0;
        if (memWe) begin
          mem[memAddr] = memWdata;
          wrCount++;
        end else begin
          memRdata = mem[memAddr];
          rdBeats++;
          rdLog.push_back(memAddr);
        end
      end else begin
        waitCnt++;
      end
    end else begin
      memAck = 1'b0;
      if (!memReq) waitCnt = 0;
    end
  end

  // invalidation monitor
  int invCount = 0;
  logic [LINE_W-1:0] lastInv = '0;
  always @(negedge clk) begin
    if (rstN && invOutValid) begin
      invCount++;
      lastInv = invOutAddr;
      chk(busGrant, "R6", {31'd0, busGrant}, 32'd1);
    end
  end

  // scoreboard
  logic [DATA_W-1:0] qData [$];
  bit                qWrite [$];
  string             qReq [$];
  int respCount = 0;

  always @(negedge clk) begin
    logic [DATA_W-1:0] d;
    bit w;
    string r;
    if (rstN && cpuRespValid) begin
      respCount++;
      if (qData.size() == 0) begin
        chk(0, "R2", cpuRdata, 32'd0);
      end else begin
        d = qData.pop_front();
        w = qWrite.pop_front();
        r = qReq.pop_front();
        if (!w) chk(cpuRdata == d, r, cpuRdata, d);
      end
    end
  end

  task automatic access(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                        input string req, input int expBeats, input bit sameSnoop,
                        input logic [LINE_W-1:0] sLine);
    int b0, w0, i0, r0;
    b0 = rdBeats; w0 = wrCount; i0 = invCount; r0 = respCount;
    qData.push_back(we ? '0 : mem[a]);
    qWrite.push_back(we);
    qReq.push_back(req);
    @(negedge clk);
    while (!cpuReady) @(negedge clk);
    cpuReqValid = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = wd;
    if (sameSnoop) begin snpValid = 1'b1; snpAddr = sLine; end
    @(negedge clk);
    cpuReqValid = 1'b0; snpValid = 1'b0;
    if (!we && expBeats == 0) chk(cpuRespValid, "R3", {31'd0, cpuRespValid}, 32'd1);
    while (respCount == r0) @(negedge clk);
    chk(rdBeats - b0 == expBeats, req, rdBeats - b0, expBeats);
    if (we) begin
      chk(mem[a] == wd, "R4", mem[a], wd);
      chk(wrCount - w0 == 1, "R4", wrCount - w0, 1);
      chk(invCount - i0 == 1, "R6", invCount - i0, 1);
      chk(lastInv == a[ADDR_W-1:2], "R6", lastInv, a[ADDR_W-1:2]);
    end else begin
      chk(invCount == i0, "R11", invCount, i0);
    end
  endtask

  task automatic snoop(input logic [LINE_W-1:0] l);
    @(negedge clk);
    snpValid = 1'b1; snpAddr = l;
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int i0;
    int r0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(cpuReady, "R1", {31'd0, cpuReady}, 32'd1);
    chk(!memReq, "R1", {31'd0, memReq}, 32'd0);
    chk(!invOutValid, "R1", {31'd0, invOutValid}, 32'd0);

    // first load misses (R1), full line read in order (R2)
    access(0, 10'h011, '0, "R2", 4, 0, '0);
    chk(rdLog.size() == 4, "R2", rdLog.size(), 4);
    for (int k = 0; k < 4; k++) begin
      logic [ADDR_W-1:0] got;
      got = rdLog.pop_front();
      chk(got == ADDR_W'(10'h010 + k), "R2", got, 10'h010 + k);
    end

    // hit on same line
    access(0, 10'h013, '0, "R3", 0, 0, '0);

    // store hit updates copy
    access(1, 10'h012, 32'h1111_2222, "R4", 0, 0, '0);
    access(0, 10'h012, '0, "R5", 0, 0, '0);

    // store miss: no allocation
    access(1, 10'h031, 32'h3333_0001, "R4", 0, 0, '0);
    access(0, 10'h010, '0, "R5", 0, 0, '0);
    access(0, 10'h031, '0, "R5", 4, 0, '0);

    // non-matching tag snoop ignored
    i0 = invCount;
    snoop(8'h04);
    access(0, 10'h032, '0, "R8", 0, 0, '0);
    chk(invCount == i0, "R11", invCount, i0);

    // matching snoop invalidates; peer value visible
    mem[10'h033] = 32'hBEEF_0001;
    snoop(8'h0C);
    chk(invCount == i0, "R11", invCount, i0);
    access(0, 10'h033, '0, "R7", 4, 0, '0);

    // same-cycle snoop on another line: still hits
    access(0, 10'h030, '0, "R8", 0, 1, 8'h05);

    // same-cycle snoop on this line: applied first
    mem[10'h030] = 32'hBEEF_0002;
    access(0, 10'h030, '0, "R9", 4, 1, 8'h0C);

    // snoop during fill
    fork
      access(0, 10'h041, '0, "R10", 4, 0, '0);
      begin
        @(negedge clk);
        while (!memReq) @(negedge clk);
        snoop(8'h10);
      end
    join
    access(0, 10'h041, '0, "R10", 4, 0, '0);

    // store waits for bus grant
    busGrant = 1'b0;
    i0 = invCount;
    r0 = respCount;
    fork
      access(1, 10'h042, 32'h4242_4242, "R4", 0, 0, '0);
      begin
        repeat (14) @(negedge clk);
        chk(mem[10'h042] == 32'h4242_4242, "R4", mem[10'h042], 32'h4242_4242);
        chk(invCount == i0, "R6", invCount, i0);
        chk(respCount == r0, "R6", respCount, r0);
        busGrant = 1'b1;
      end
    join

    chk(holdErr == 0, "R12", holdErr, 0);
    chk(qData.size() == 0, "R2", qData.size(), 0);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule